// File: doc/BRIEF.md
# Strip-Mined 2x2 Convolution Engine

This block is a streaming datapath that slides a fixed 2x2 weighted window along two neighbouring image rows. Each accepted transfer carries one 64-bit word from an upper row and the word holding the same eight columns of the row directly below it. Every word holds eight unsigned 8-bit pixels. The block returns the seven window results that lie wholly inside those eight columns, packed into a 56-bit bus.

The kernel is built into the logic. The two diagonal taps that weigh twice are left shifts by one bit, so the datapath contains no multiplier. Each window sum is formed at full precision and then reduced to 8 bits by dropping the upper bits. One output register sits between a valid/ready pair on the input side and a valid/ready pair on the output side. Line buffering, address generation, border handling and windows that span two words belong to the surrounding logic.

Top module: `conv2x2_strip`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `in_ready` is 1.
- R2: Pixel column k (k = 0..7) of each row word is bits [8k+7:8k]. Result k (k = 0..6) is bits [8k+7:8k] of `out_win`. It equals A[k] + 2·A[k+1] + 2·B[k] + B[k+1], where A is the upper row (`in_row_a`) and B is the lower row (`in_row_b`).
- R3: Each result is the low 8 bits of its full sum, which is at most 1530. With every pixel at 255, every lane reads 0xFA.
- R4: A word accepted at a rising edge (`in_valid` and `in_ready` both high) appears on `out_win` with `out_valid` high right after that same edge.
- R5: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. A word offered while `in_ready` is low is not taken.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_win` holds its value.
- R7: When a result is taken and no new word is accepted in the same cycle, `out_valid` falls after that edge.
- R8: With `out_ready` held high, words offered on consecutive cycles are accepted one per cycle and come out in order, one per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| in_valid | input | 1 | Row word pair is offered |
| in_ready | output | 1 | Block can take a row word pair this cycle |
| in_row_a | input | 64 | Eight pixels of the upper row |
| in_row_b | input | 64 | Eight pixels of the lower row, same columns |
| out_valid | output | 1 | `out_win` holds a result set |
| out_ready | input | 1 | Consumer takes the result set this cycle |
| out_win | output | 56 | Seven packed 8-bit window results |

## Verification
A lane fed from the wrong columns, or a tap with the wrong weight, shows up at the ports in the first result after the faulty input is taken. Single-pixel patterns make it obvious which lane and which tap is wrong. A valid flag or output register that loses its state under backpressure shows up within one cycle of a stall: the held result changes, or `in_ready` rises while the output is still full. A dropped or duplicated transfer during a back-to-back stream breaks the sequence of outputs at the next sample. An error in the wrap to 8 bits stays hidden until the sums pass 255, so the all-255 case checks it directly.

// File: rtl/conv2x2_pkg.sv
package conv2x2_pkg;
  // Pixel width and pixels per row word
  localparam int unsigned PIX_W  = 8;
  localparam int unsigned LANES  = 8;
  // Derived widths
  localparam int unsigned WIN    = LANES - 1;
  localparam int unsigned WORD_W = LANES * PIX_W;
  localparam int unsigned RES_W  = WIN * PIX_W;
  // Full sum of four taps with weights 1,2,2,1 (total weight 6) fits PIX_W+3 bits
  localparam int unsigned SUM_W  = PIX_W + 3;
endpackage

// File: rtl/conv2x2_lane.sv
module conv2x2_lane #(
  parameter int unsigned PIX_W = 8
) (
  input  logic [PIX_W-1:0] up_l,
  input  logic [PIX_W-1:0] up_r,
  input  logic [PIX_W-1:0] dn_l,
  input  logic [PIX_W-1:0] dn_r,
  output logic [PIX_W-1:0] res
);
  localparam int unsigned SUM_W = PIX_W + 3;
  localparam int unsigned PAD   = SUM_W - PIX_W;

  logic [SUM_W-1:0] w_ul, w_ur, w_dl, w_dr;
  logic [SUM_W-1:0] pair_top, pair_bot, full_sum;

  always_comb begin
    // zero-extend, weight-two taps become a one-bit left shift
    w_ul     = {{PAD{1'b0}}, up_l};
    w_ur     = {{PAD{1'b0}}, up_r} << 1;
    w_dl     = {{PAD{1'b0}}, dn_l} << 1;
    w_dr     = {{PAD{1'b0}}, dn_r};
    pair_top = w_ul + w_ur;
    pair_bot = w_dl + w_dr;
    full_sum = pair_top + pair_bot;
    // keep the low pixel-width bits (modulo 2^PIX_W)
    res      = full_sum[PIX_W-1:0];
  end
endmodule

// File: rtl/conv2x2_array.sv
module conv2x2_array #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned LANES = 8
) (
  input  logic [LANES*PIX_W-1:0]     row_top,
  input  logic [LANES*PIX_W-1:0]     row_bot,
  output logic [(LANES-1)*PIX_W-1:0] win_res
);
  localparam int unsigned WIN = LANES - 1;

  for (genvar k = 0; k < WIN; k++) begin : g_win
    conv2x2_lane #(.PIX_W(PIX_W)) u_lane (
      .up_l (row_top[k*PIX_W     +: PIX_W]),
      .up_r (row_top[(k+1)*PIX_W +: PIX_W]),
      .dn_l (row_bot[k*PIX_W     +: PIX_W]),
      .dn_r (row_bot[(k+1)*PIX_W +: PIX_W]),
      .res  (win_res[k*PIX_W     +: PIX_W])
    );
  end
endmodule

// File: rtl/conv2x2_ostage.sv
module conv2x2_ostage #(
  parameter int unsigned W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_valid,
  output logic         load_ready,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q, vld_d;
  logic         dat_en;
  logic         take;
  logic [W-1:0] dat_q;

  // next-state logic
  always_comb begin
    load_ready = !vld_q || out_ready;
    take       = load_valid && load_ready;
    dat_en     = take;
    if (take)           vld_d = 1'b1;
    else if (out_ready) vld_d = 1'b0;
    else                vld_d = vld_q;
  end

  // control register with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  // data register, enable only, no reset
  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= load_data;
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

  // R6: a stalled result stays valid and unchanged
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R4: an accepted word is presented after the next edge
  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> out_valid);

  // R7: a taken result with nothing behind it empties the stage
  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !load_valid) |=> !out_valid);
endmodule

// File: rtl/conv2x2_strip.sv
module conv2x2_strip
  import conv2x2_pkg::*;
#(
  parameter int unsigned P_PIX_W = PIX_W,
  parameter int unsigned P_LANES = LANES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [P_LANES*P_PIX_W-1:0]   in_row_a,
  input  logic [P_LANES*P_PIX_W-1:0]   in_row_b,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [(P_LANES-1)*P_PIX_W-1:0] out_win
);
  localparam int unsigned OUT_W = (P_LANES - 1) * P_PIX_W;

  logic [OUT_W-1:0] win_comb;

  conv2x2_array #(.PIX_W(P_PIX_W), .LANES(P_LANES)) u_array (
    .row_top (in_row_a),
    .row_bot (in_row_b),
    .win_res (win_comb)
  );

  conv2x2_ostage #(.W(OUT_W)) u_ostage (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_valid (in_valid),
    .load_ready (in_ready),
    .load_data  (win_comb),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_win)
  );

  // R5: a word refused at the input leaves the held result untouched
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> (out_valid && $stable(out_win)));
endmodule

// File: tb/sim_conv2x2_strip.sv
`timescale 1ns/1ps
module sim_conv2x2_strip;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [63:0] in_row_a, in_row_b;
  logic [55:0] out_win;
  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  conv2x2_strip u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_row_a(in_row_a), .in_row_b(in_row_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_win(out_win)
  );

  function automatic logic [55:0] ref_win(input logic [63:0] a, input logic [63:0] b);
    logic [55:0] r;
    for (int k = 0; k < 7; k++) begin
      int s;
      s = int'(a[8*k +: 8]) + 2*int'(a[8*(k+1) +: 8])
        + 2*int'(b[8*k +: 8]) + int'(b[8*(k+1) +: 8]);
      r[8*k +: 8] = 8'(s % 256);
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_row_a = '0; in_row_b = '0;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", 64'(out_valid), 64'd0);
  endtask

  // one word through with consumer ready, then drain
  task automatic t_single(input string req, input logic [63:0] a, input logic [63:0] b);
    out_ready = 1'b1; in_valid = 1'b1; in_row_a = a; in_row_b = b;
    #1 chk({req, " in_ready"}, 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0; in_row_a = '1; in_row_b = '1;
    chk({req, " R4 valid"}, 64'(out_valid), 64'd1);
    chk({req, " data"}, 64'(out_win), 64'(ref_win(a, b)));
    @(negedge clk);
    chk({req, " R7 drained"}, 64'(out_valid), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [63:0] a0 = 64'h0123_4567_89AB_CDEF, b0 = 64'hFEDC_BA98_7654_3210;
    logic [63:0] a1 = 64'h1111_2222_3333_4444, b1 = 64'h5555_6666_7777_8888;
    out_ready = 1'b0; in_valid = 1'b1; in_row_a = a0; in_row_b = b0;
    @(negedge clk);
    in_row_a = a1; in_row_b = b1;
    #1 chk("R5 stalled in_ready", 64'(in_ready), 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 held valid", 64'(out_valid), 64'd1);
      chk("R6 held data", 64'(out_win), 64'(ref_win(a0, b0)));
    end
    out_ready = 1'b1;
    #1 chk("R5 ready with consumer", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 second word", 64'(out_win), 64'(ref_win(a1, b1)));
    @(negedge clk);
    chk("R7 drained after stall", 64'(out_valid), 64'd0);
  endtask

  task automatic t_stream();
    logic [63:0] a, b, pa, pb;
    out_ready = 1'b1;
    for (int i = 0; i < 6; i++) begin
      a = {8{8'(i*37 + 5)}} ^ (64'h0F1E_2D3C_4B5A_6978 << i);
      b = {8{8'(i*91 + 3)}} + 64'h0102_0304_0506_0708 * (i + 1);
      in_valid = 1'b1; in_row_a = a; in_row_b = b;
      @(negedge clk);
      chk("R8 stream valid", 64'(out_valid), 64'd1);
      chk("R8 stream data", 64'(out_win), 64'(ref_win(a, b)));
      pa = a; pb = b;
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 stream end", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single("R2 lane positions upper", 64'h0000_0000_0100_0000, 64'd0);
    t_single("R2 lane positions lower", 64'd0, 64'h0000_0000_0100_0000);
    t_single("R2 ramp", 64'h0807_0605_0403_0201, 64'h1020_3040_5060_7080);
    t_single("R3 all 255 wrap", '1, '1);
    chk("R3 lane value", 64'(ref_win('1, '1)), {8'h00, {7{8'hFA}}});
    t_backpressure();
    t_stream();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule